// File: doc/BRIEF.md
# Locked-Sequence Bus Release Controller

This block is the ownership side of a bus master. It issues bus cycles that a simple command interface asks for, either one plain cycle or a unit of several atomic cycles that must be seen as locked, and it decides when to hand the bus back after an external arbiter withdraws the grant. A qualifier input travels with the grant. When the qualifier is high, the master leaves as soon as the cycle in flight terminates, even in the middle of a locked unit. When the qualifier is low, the master finishes the whole locked unit first, so the unit is never split.

Each cycle starts with a one-clock start strobe and ends with either a normal acknowledge or a retry. A retry reissues the same cycle and never releases the bus. During a locked unit, a lock output stays high from the start strobe of the first cycle until the clock after the final acknowledge. A lock-end output marks the last cycle of the unit, so an arbiter can see where one unit ends and the next begins. A one-clock hand-off pulse signals that ownership has been given up. Cycles resume after the grant returns, and a unit that was cut short continues with the cycles it had left.

Top module: `brc_top`

## Requirements
- R1: After reset, `start_o`, `lock_o`, `lock_end_o` and `tenure_o` are low and `cmd_ready_o` is low, because the block does not own the bus.
- R2: `lock_o` rises in the same clock as the `start_o` of the first cycle of a locked unit. `lock_end_o` is high with the `start_o` of the last cycle of the unit and never high while `lock_o` is low. A plain command never raises either signal.
- R3: `lock_o` stays high through wait states, retries and intermediate acknowledges, and it falls in the clock after the acknowledge of the last cycle.
- R4: A retry (`retry_i` high while a cycle is outstanding; retry wins over a simultaneous `ack_i`) gives a new `start_o` in the next clock for the same cycle. `lock_o` and `lock_end_o` do not change and the unit does not advance.
- R5: If the grant is low and the qualifier low at an acknowledge inside a locked unit, the remaining cycles are still issued. The bus is released only after the acknowledge of the last cycle of the unit.
- R6: If the grant is low and the qualifier high at an acknowledge, the bus is released after that cycle, even mid-unit, and `lock_o` drops. The cycles left in the unit stay pending and `cmd_ready_o` remains low. After the grant returns, they are issued before any new command, and `lock_o` rises again with the first resumed start.
- R7: With locked units presented back to back, a release pending at the end of the current unit happens at its last acknowledge, before the next unit is accepted.
- R8: `tenure_o` is a single-clock pulse in the clock after the acknowledge that triggers it. It is issued only if the grant was low at that acknowledge, and `lock_o` is low while it is high.
- R9: While released, the block makes no `start_o` and holds `cmd_ready_o` low. In the clock after the grant is sampled high, the block owns the bus and `cmd_ready_o` is high if nothing is pending.
- R10: A plain command (`cmd_lock_i` = 0) issues exactly one cycle whatever `cmd_count_i` holds.
- R11: For a locked command, `cmd_count_i` is the number of cycles in the unit. The values 0 and 1 both give a single cycle, and that cycle carries `lock_end_o`.
- R12: A retry never releases the bus, whatever the grant and the qualifier are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every input is sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| grant_i | input | 1 | Bus grant from the external arbiter |
| yield_now_i | input | 1 | Grant qualifier; when high, leave after the current cycle rather than after the locked unit |
| cmd_valid_i | input | 1 | A command is offered |
| cmd_lock_i | input | 1 | The command is a locked unit |
| cmd_count_i | input | CNT_W | Number of cycles in a locked unit |
| cmd_ready_o | output | 1 | Command is accepted this clock when `cmd_valid_i` is high |
| ack_i | input | 1 | Normal termination of the outstanding cycle |
| retry_i | input | 1 | Retry termination of the outstanding cycle |
| start_o | output | 1 | One-clock transfer-start strobe |
| lock_o | output | 1 | Locked unit in progress |
| lock_end_o | output | 1 | Current cycle is the last of its locked unit |
| tenure_o | output | 1 | One-clock pulse that hands off bus ownership |

## Verification
Properties checked on every clock cover the following rules:
- `lock_o` rises only together with a start strobe, and `lock_end_o` lies inside `lock_o`.
- A retry is followed by a restart with unchanged lock state and no hand-off.
- The hand-off pulse is one clock long, follows a low grant and comes with `lock_o` low.
- The block stays silent while it is released.
- The unit counter never underflows.

Some behaviour can only be shown by the bench's scenarios, which use a scoreboard of expected start strobes:
- whether a release waits for the end of a unit or happens mid-unit, depending on the qualifier;
- that pending cycles resume after the grant returns;
- that a back-to-back unit is not started before a release;
- the cycle counts for the boundary values 0 and 1.

// File: rtl/brc_pkg.sv
package brc_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_IDLE = 2'd1,
        ST_BUSY = 2'd2
    } own_state_e;

    typedef struct packed {
        own_state_e st;
        logic       start;
        logic       lock;
        logic       lend;
        logic       xfer;
        logic       grp_locked;
        logic       pend;
    } ctl_regs_t;

    localparam ctl_regs_t CTL_RESET = '{
        st:         ST_OFF,
        start:      1'b0,
        lock:       1'b0,
        lend:       1'b0,
        xfer:       1'b0,
        grp_locked: 1'b0,
        pend:       1'b0
    };

endpackage

// File: rtl/brc_unit_counter.sv
module brc_unit_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             dec_i,
    output logic             none_left_o,
    output logic             one_left_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] rem_d, rem_q;

    always_comb begin
        rem_d = rem_q;
        if (load_i) begin
            rem_d = (count_i == '0) ? '0 : count_i - ONE;
        end else if (dec_i) begin
            rem_d = rem_q - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else begin
            rem_q <= rem_d;
        end
    end

    assign none_left_o = (rem_q == '0);
    assign one_left_o  = (rem_q == ONE);

    // R4 / R11: an advance is only requested while cycles remain
    a_r11_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !load_i) |-> (rem_q != '0));

endmodule

// File: rtl/brc_release_policy.sv
module brc_release_policy (
    input  logic ack_done_i,
    input  logic grant_i,
    input  logic yield_now_i,
    input  logic unit_last_i,
    output logic release_o,
    output logic split_o
);
    logic gone;

    always_comb begin
        gone      = ack_done_i && !grant_i;
        release_o = gone && (yield_now_i || unit_last_i);
        split_o   = gone && yield_now_i && !unit_last_i;
    end

endmodule

// File: rtl/brc_top.sv
module brc_top #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             grant_i,
    input  logic             yield_now_i,
    input  logic             cmd_valid_i,
    input  logic             cmd_lock_i,
    input  logic [CNT_W-1:0] cmd_count_i,
    output logic             cmd_ready_o,
    input  logic             ack_i,
    input  logic             retry_i,
    output logic             start_o,
    output logic             lock_o,
    output logic             lock_end_o,
    output logic             tenure_o
);
    import brc_pkg::*;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    ctl_regs_t r_q, r_d;

    logic cnt_load, cnt_dec, cnt_none, cnt_one;
    logic ack_done, unit_last, rel, split;
    logic accept, resume;

    brc_unit_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (cnt_load),
        .count_i     (cmd_count_i),
        .dec_i       (cnt_dec),
        .none_left_o (cnt_none),
        .one_left_o  (cnt_one)
    );

    assign ack_done  = (r_q.st == ST_BUSY) && ack_i && !retry_i;
    assign unit_last = !r_q.grp_locked || cnt_none;

    brc_release_policy u_pol (
        .ack_done_i  (ack_done),
        .grant_i     (grant_i),
        .yield_now_i (yield_now_i),
        .unit_last_i (unit_last),
        .release_o   (rel),
        .split_o     (split)
    );

    assign cmd_ready_o = (r_q.st == ST_IDLE) && grant_i && !r_q.pend;
    assign accept      = cmd_ready_o && cmd_valid_i;
    assign resume      = (r_q.st == ST_IDLE) && grant_i && r_q.pend;

    always_comb begin
        r_d      = r_q;
        r_d.start = 1'b0;
        r_d.xfer  = 1'b0;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        unique case (r_q.st)
            ST_OFF: begin
                if (grant_i) begin
                    r_d.st = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (!grant_i) begin
                    r_d.st   = ST_OFF;
                    r_d.xfer = 1'b1;
                end else if (resume) begin
                    r_d.st    = ST_BUSY;
                    r_d.start = 1'b1;
                    r_d.lock  = 1'b1;
                    r_d.lend  = cnt_one;
                    r_d.pend  = 1'b0;
                    cnt_dec   = 1'b1;
                end else if (accept) begin
                    r_d.st         = ST_BUSY;
                    r_d.start      = 1'b1;
                    r_d.lock       = cmd_lock_i;
                    r_d.lend       = cmd_lock_i && (cmd_count_i <= ONE);
                    r_d.grp_locked = cmd_lock_i;
                    cnt_load       = 1'b1;
                end
            end
            ST_BUSY: begin
                if (retry_i) begin
                    r_d.start = 1'b1;
                end else if (ack_i) begin
                    if (rel) begin
                        r_d.st   = ST_OFF;
                        r_d.xfer = 1'b1;
                        r_d.lock = 1'b0;
                        r_d.lend = 1'b0;
                        r_d.pend = split;
                    end else if (!unit_last) begin
                        r_d.start = 1'b1;
                        r_d.lock  = 1'b1;
                        r_d.lend  = cnt_one;
                        cnt_dec   = 1'b1;
                    end else begin
                        r_d.st   = ST_IDLE;
                        r_d.lock = 1'b0;
                        r_d.lend = 1'b0;
                    end
                end
            end
            default: r_d = CTL_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= CTL_RESET;
        end else begin
            r_q <= r_d;
        end
    end

    assign start_o    = r_q.start;
    assign lock_o     = r_q.lock;
    assign lock_end_o = r_q.lend;
    assign tenure_o   = r_q.xfer;

    // R2: lock rises only with a start strobe
    a_r2_lock_with_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> start_o);

    // R2: lock-end never outside lock
    a_r2_end_inside_lock: assert property (@(posedge clk) disable iff (!rst_n)
        lock_end_o |-> lock_o);

    // R3: lock held while a locked cycle waits
    a_r3_hold_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_BUSY && lock_o && !ack_i) |=> lock_o);

    // R4: a retry restarts the same cycle with unchanged lock state
    a_r4_retry_reissue: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_BUSY && retry_i) |=> (start_o && $stable(lock_o) && $stable(lock_end_o)));

    // R12: a retry never hands the bus off
    a_r12_retry_keeps_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_BUSY && retry_i) |=> !tenure_o);

    // R8: hand-off is a single pulse
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tenure_o |=> !tenure_o);

    // R8: hand-off only after a low grant, with lock dropped
    a_r8_after_low_grant: assert property (@(posedge clk) disable iff (!rst_n)
        tenure_o |-> (!$past(grant_i) && !lock_o));

    // R9: silent while released
    a_r9_quiet_released: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_OFF) |-> (!start_o && !cmd_ready_o));

endmodule

// File: tb/tb_brc_top.sv
module tb_brc_top;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 4;

    typedef struct packed { logic lk; logic le; } exp_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             grant_i = 1'b0, yield_now_i = 1'b0;
    logic             cmd_valid_i = 1'b0, cmd_lock_i = 1'b0;
    logic [CNT_W-1:0] cmd_count_i = '0;
    logic             ack_i = 1'b0, retry_i = 1'b0;
    logic             cmd_ready_o, start_o, lock_o, lock_end_o, tenure_o;

    int   total = 0;
    int   bad   = 0;
    bit   done  = 1'b0;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    brc_top #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .grant_i(grant_i), .yield_now_i(yield_now_i),
        .cmd_valid_i(cmd_valid_i), .cmd_lock_i(cmd_lock_i), .cmd_count_i(cmd_count_i),
        .cmd_ready_o(cmd_ready_o), .ack_i(ack_i), .retry_i(retry_i),
        .start_o(start_o), .lock_o(lock_o), .lock_end_o(lock_end_o), .tenure_o(tenure_o)
    );

    task automatic check(input string req, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // monitor: every start strobe pops one expected cycle
    always @(negedge clk) begin
        if (rst_n && start_o) begin
            if (exp_q.size() == 0) begin
                total++;
                bad++;
                $display("FAIL R9 unexpected start: actual=1 expected=0");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check("R2 lock with start", int'(lock_o), int'(e.lk));
                check("R2 lock_end with start", int'(lock_end_o), int'(e.le));
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic push(input logic lk, input logic le);
        exp_t e;
        e.lk = lk;
        e.le = le;
        exp_q.push_back(e);
    endtask

    task automatic send(input logic lk, input int n);
        while (!cmd_ready_o) tick();
        cmd_valid_i = 1'b1;
        cmd_lock_i  = lk;
        cmd_count_i = CNT_W'(n);
        tick();
        cmd_valid_i = 1'b0;
    endtask

    task automatic term(input logic is_retry);
        if (is_retry) retry_i = 1'b1; else ack_i = 1'b1;
        tick();
        retry_i = 1'b0;
        ack_i   = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        check("R1 start", int'(start_o), 0);
        check("R1 lock", int'(lock_o), 0);
        check("R1 lock_end", int'(lock_end_o), 0);
        check("R1 tenure", int'(tenure_o), 0);
        check("R1 ready", int'(cmd_ready_o), 0);

        grant_i = 1'b1;
        tick();
        check("R9 ready after grant", int'(cmd_ready_o), 1);

        // A: locked unit of 3 with wait states
        push(1, 0); push(1, 0); push(1, 1);
        send(1, 3);
        tick(); tick();
        check("R3 lock in wait", int'(lock_o), 1);
        term(0); term(0); term(0);
        check("R3 lock drops after last ack", int'(lock_o), 0);
        check("R8 no release with grant", int'(tenure_o), 0);

        // B: retry on last locked cycle, grant gone with yield
        push(1, 0); push(1, 1); push(1, 1);
        send(1, 2);
        term(0);
        grant_i = 1'b0; yield_now_i = 1'b1;
        term(1);
        check("R4 lock kept on retry", int'(lock_o), 1);
        check("R4 lock_end kept on retry", int'(lock_end_o), 1);
        check("R12 no release on retry", int'(tenure_o), 0);
        term(0);
        check("R8 release pulse", int'(tenure_o), 1);
        check("R8 lock low on release", int'(lock_o), 0);
        grant_i = 1'b1; yield_now_i = 1'b0;
        tick();

        // C: grant low, qualifier low: unit completes
        push(1, 0); push(1, 0); push(1, 1);
        send(1, 3);
        term(0);
        grant_i = 1'b0;
        term(0);
        check("R5 no mid-unit release", int'(tenure_o), 0);
        check("R5 lock held", int'(lock_o), 1);
        term(0);
        check("R5 release after unit", int'(tenure_o), 1);
        tick();
        check("R8 pulse is one clock", int'(tenure_o), 0);
        cmd_valid_i = 1'b1; cmd_lock_i = 1'b0; cmd_count_i = CNT_W'(5);
        for (int i = 0; i < 3; i++) begin
            check("R9 ready low while released", int'(cmd_ready_o), 0);
            tick();
        end
        push(0, 0);
        grant_i = 1'b1;
        tick();
        check("R9 ready one clock after grant", int'(cmd_ready_o), 1);
        tick();
        cmd_valid_i = 1'b0;
        check("R10 plain cycle no lock", int'(lock_o), 0);
        term(0);
        check("R10 single cycle", int'(start_o), 0);

        // D: qualifier high: mid-unit release then resume
        push(1, 0); push(1, 0);
        send(1, 4);
        term(0);
        grant_i = 1'b0; yield_now_i = 1'b1;
        term(0);
        check("R6 mid-unit release", int'(tenure_o), 1);
        check("R6 lock dropped", int'(lock_o), 0);
        tick();
        grant_i = 1'b1; yield_now_i = 1'b0;
        push(1, 0); push(1, 1);
        cmd_valid_i = 1'b1; cmd_lock_i = 1'b0;
        tick();
        check("R6 ready low while pending", int'(cmd_ready_o), 0);
        tick();
        check("R6 resumed start", int'(start_o), 1);
        cmd_valid_i = 1'b0;
        term(0); term(0);
        check("R6 unit ends", int'(lock_o), 0);

        // E: back-to-back units, release between them
        push(1, 0); push(1, 1);
        send(1, 2);
        cmd_valid_i = 1'b1; cmd_lock_i = 1'b1; cmd_count_i = CNT_W'(2);
        grant_i = 1'b0;
        term(0);
        term(0);
        check("R7 release at unit end", int'(tenure_o), 1);
        tick(); tick();
        check("R7 next unit not started", int'(start_o), 0);
        push(1, 0); push(1, 1);
        grant_i = 1'b1;
        tick();
        tick();
        cmd_valid_i = 1'b0;
        term(0); term(0);
        check("R7 second unit done", int'(lock_o), 0);

        // F: count boundaries
        push(1, 1);
        send(1, 0);
        term(0);
        check("R11 count 0 single", int'(lock_o), 0);
        push(1, 1);
        send(1, 1);
        term(0);
        check("R11 count 1 single", int'(lock_o), 0);

        repeat (3) tick();
        check("R2 all expected starts seen", exp_q.size(), 0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule